// File: doc/BRIEF.md
# GPIO interrupt detector with shared glitch filter

This block is the interrupt front end that sits between a bank of GPIO-derived interrupt lines and a parent interrupt controller. Each line is brought into the clock domain through a two-stage synchroniser. It can then pass through a glitch filter. The filter accepts a new level only after the input has held that level for a programmed number of clock cycles. One period value serves every line. The filtered level then goes through a per-line output stage that drives the parent.

Software sets up the block through a small register window. The window holds four registers:
- a per-line enable register;
- a per-line mode register, where each bit chooses either level pass-through or both-edge reporting;
- a per-line filter-enable register;
- a single filter-period register.

In pass-through mode the parent receives the accepted level and applies its own sense. In both-edge mode the output rests high and drops low for one clock on every accepted transition in either direction, so a parent set for falling edges sees each change. Both-edge reporting works only on a line whose filter is switched on.

Top module: `gpio_irq_front`

## Requirements
- R1: After reset the enable, mode and filter-enable registers read 0, the period register reads 0xFF, and every output is 0.
- R2: A write with `reg_wr_en` high updates the register at its byte address: enable at 0x90, mode at 0x94, filter-enable at 0x98 (bit i controls line i), and period at 0x9C (low 8 bits). `reg_rdata` returns the addressed register zero-extended. A write to any other address changes nothing and reads back 0.
- R3: In pass-through mode with the filter off and the line enabled, the output equals the input level from three rising edges earlier.
- R4: With the filter on, the accepted level changes only after the synchronised input has differed from it for P consecutive cycles, where P is the period value and 0 counts as 1. The output then changes on rising edge 2+P after the input changes.
- R5: Any return of the input to the accepted level before P cycles have passed restarts the count. Two bursts of P-1 cycles separated by one cycle never change the output.
- R6: A line whose enable bit is 0 outputs 0 in pass-through mode and 1 in both-edge mode, whatever its input does.
- R7: In both-edge mode with the filter on and the line enabled, the output idles at 1 and is 0 for exactly one cycle per accepted rising or falling transition.
- R8: In both-edge mode with the filter off, the output stays at 1 and emits no pulses.
- R9: The single period value governs every filtered line at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| irq_in | input | 24 | Raw interrupt lines, asynchronous |
| irq_out | output | 24 | Per-line signals to the parent controller |

## Verification
On every cycle the assertions check four properties:
- a masked or unfiltered both-edge line keeps its idle level;
- a filtered line only ever takes the level its synchroniser showed;
- the filter counter clears whenever the input agrees with the accepted level;
- writes outside the window leave every register untouched.

Only the bench scenarios can show the timing behaviour. These are the exact edge on which a filtered level is accepted and the equality between the pulse width and the period. They also cover the count restart after a glitch, the number of low cycles per pulse in both-edge mode, and the sharing of one period by several lines.

// File: rtl/gpio_irq_pkg.sv
// Shared constants for the GPIO interrupt front end: register window
// offsets and default sizes. Assumes byte addressing, word-aligned registers.
package gpio_irq_pkg;
    localparam int unsigned AW         = 8;
    localparam int unsigned DW         = 32;
    localparam logic [AW-1:0] ADDR_EN  = 8'h90;
    localparam logic [AW-1:0] ADDR_MOD = 8'h94;
    localparam logic [AW-1:0] ADDR_FLT = 8'h98;
    localparam logic [AW-1:0] ADDR_PER = 8'h9C;
    localparam logic [7:0]    PER_RST  = 8'hFF;
endpackage

// File: rtl/gil_regs.sv
// Control register window: per-line enable, mode and filter-enable words
// plus one shared filter period. Assumes NUM_LINES < DW and PER_W <= 8.
module gil_regs
    import gpio_irq_pkg::*;
#(
    parameter int unsigned NUM_LINES = 24,
    parameter int unsigned PER_W     = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [AW-1:0]        addr,
    input  logic [DW-1:0]        wdata,
    output logic [DW-1:0]        rdata,
    output logic [NUM_LINES-1:0] en_o,
    output logic [NUM_LINES-1:0] mode_o,
    output logic [NUM_LINES-1:0] flt_o,
    output logic [PER_W-1:0]     period_o
);
    localparam int unsigned PAD_L = DW - NUM_LINES;
    localparam int unsigned PAD_P = DW - PER_W;

    logic [NUM_LINES-1:0] en_q, mode_q, flt_q;
    logic [PER_W-1:0]     per_q;
    logic                 hit;

    // Decode whether the address falls on one of the four registers.
    always_comb begin
        hit = (addr == ADDR_EN) || (addr == ADDR_MOD) ||
              (addr == ADDR_FLT) || (addr == ADDR_PER);
    end

    // Register update on a write strobe, reset to defaults.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            mode_q <= '0;
            flt_q  <= '0;
            per_q  <= PER_RST[PER_W-1:0];
        end else if (wr_en) begin
            if (addr == ADDR_EN)  en_q   <= wdata[NUM_LINES-1:0];
            if (addr == ADDR_MOD) mode_q <= wdata[NUM_LINES-1:0];
            if (addr == ADDR_FLT) flt_q  <= wdata[NUM_LINES-1:0];
            if (addr == ADDR_PER) per_q  <= wdata[PER_W-1:0];
        end
    end

    // Read multiplexer, zero-extending each register.
    always_comb begin
        unique case (addr)
            ADDR_EN:  rdata = {{PAD_L{1'b0}}, en_q};
            ADDR_MOD: rdata = {{PAD_L{1'b0}}, mode_q};
            ADDR_FLT: rdata = {{PAD_L{1'b0}}, flt_q};
            ADDR_PER: rdata = {{PAD_P{1'b0}}, per_q};
            default:  rdata = '0;
        endcase
    end

    assign en_o     = en_q;
    assign mode_o   = mode_q;
    assign flt_o    = flt_q;
    assign period_o = per_q;

    // R2: writes outside the window leave every register as it was.
    p_ignore_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !hit) |=> ($stable(en_q) && $stable(mode_q) &&
                             $stable(flt_q) && $stable(per_q)));
endmodule

// File: rtl/gil_line_filter.sv
// One line's input path: two-flop synchroniser, then either a direct
// follower or a hold-time glitch filter that adopts a new level once the
// synchronised input has differed for `period` cycles (0 treated as 1).
module gil_line_filter #(
    parameter int unsigned PER_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             raw,
    input  logic             flt_en,
    input  logic [PER_W-1:0] period,
    output logic             acc_o
);
    logic             sync1, sync2;
    logic             acc;
    logic [PER_W-1:0] cnt;
    logic             done;

    // Bring the asynchronous input into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1 <= 1'b0;
            sync2 <= 1'b0;
        end else begin
            sync1 <= raw;
            sync2 <= sync1;
        end
    end

    // Terminal count: this cycle completes the required hold time.
    always_comb begin
        done = (period == '0) || (cnt == period - 1'b1);
    end

    // Accepted level and hold counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= 1'b0;
            cnt <= '0;
        end else if (!flt_en) begin
            acc <= sync2;
            cnt <= '0;
        end else if (sync2 == acc) begin
            cnt <= '0;
        end else if (done) begin
            acc <= sync2;
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign acc_o = acc;

    // R4: a filtered line only ever adopts the level its synchroniser showed.
    p_adopt_sync_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(flt_en) && (acc != $past(acc))) |-> (acc == $past(sync2)));

    // R5: agreement with the accepted level restarts the hold count.
    p_cnt_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_en && (sync2 == acc)) |=> (cnt == '0));
endmodule

// File: rtl/gil_out_stage.sv
// Per-line output former: pass-through of the accepted level, or a
// one-cycle low pulse per accepted transition in both-edge mode.
// Assumes both-edge pulses are wanted only on filtered, enabled lines.
module gil_out_stage #(
    parameter int unsigned NUM_LINES = 24
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] acc,
    input  logic [NUM_LINES-1:0] en,
    input  logic [NUM_LINES-1:0] mode,
    input  logic [NUM_LINES-1:0] flt,
    output logic [NUM_LINES-1:0] out
);
    logic [NUM_LINES-1:0] prev;

    // Remember last cycle's accepted levels to spot transitions.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= '0;
        else        prev <= acc;
    end

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        logic armed;
        // Both-edge reporting needs the line enabled and filtered.
        always_comb begin
            armed = en[i] && flt[i];
        end
        // Select the line's output form from its mode bit.
        always_comb begin
            if (mode[i]) out[i] = !armed || (acc[i] == prev[i]);
            else         out[i] = en[i] && acc[i];
        end
    end
endmodule

// File: rtl/gpio_irq_front.sv
// Top of the GPIO interrupt front end: register window, one filter per
// line sharing a single period, and the output former toward the parent.
module gpio_irq_front
    import gpio_irq_pkg::*;
#(
    parameter int unsigned NUM_LINES = 24,
    parameter int unsigned PER_W     = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr_en,
    input  logic [AW-1:0]        reg_addr,
    input  logic [DW-1:0]        reg_wdata,
    output logic [DW-1:0]        reg_rdata,
    input  logic [NUM_LINES-1:0] irq_in,
    output logic [NUM_LINES-1:0] irq_out
);
    logic [NUM_LINES-1:0] en, mode, flt, acc;
    logic [PER_W-1:0]     period;

    gil_regs #(.NUM_LINES(NUM_LINES), .PER_W(PER_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .en_o(en), .mode_o(mode),
        .flt_o(flt), .period_o(period)
    );

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_flt
        gil_line_filter #(.PER_W(PER_W)) flt_i (
            .clk(clk), .rst_n(rst_n), .raw(irq_in[i]), .flt_en(flt[i]),
            .period(period), .acc_o(acc[i])
        );

        // R8: both-edge mode without the filter never leaves its idle level.
        p_nofilt_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (mode[i] && !flt[i]) |-> irq_out[i]);

        // R6: a masked line holds the idle level of its mode.
        p_masked_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
            !en[i] |-> (irq_out[i] == mode[i]));
    end

    gil_out_stage #(.NUM_LINES(NUM_LINES)) out_i (
        .clk(clk), .rst_n(rst_n), .acc(acc), .en(en), .mode(mode),
        .flt(flt), .out(irq_out)
    );
endmodule

// File: tb/gpio_irq_front_tb_top.sv
`timescale 1ns/1ps
module gpio_irq_front_tb_top;
    localparam int N = 24;
    localparam int L = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr_en = 1'b0;
    logic [7:0]    reg_addr = 8'h00;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [N-1:0]  irq_in = '0;
    logic [N-1:0]  irq_out;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    gpio_irq_front dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_in(irq_in),
        .irq_out(irq_out)
    );

    // Vector: {mode, flt, en, period[7:0], width[7:0]}
    localparam logic [18:0] VEC [9] = '{
        {1'b0, 1'b0, 1'b1, 8'hFF, 8'd3},
        {1'b0, 1'b1, 1'b1, 8'd4,  8'd3},
        {1'b0, 1'b1, 1'b1, 8'd4,  8'd4},
        {1'b0, 1'b1, 1'b0, 8'd2,  8'd6},
        {1'b1, 1'b1, 1'b1, 8'd3,  8'd5},
        {1'b1, 1'b1, 1'b1, 8'd3,  8'd2},
        {1'b1, 1'b0, 1'b1, 8'd1,  8'd5},
        {1'b1, 1'b1, 1'b0, 8'd1,  8'd5},
        {1'b0, 1'b1, 1'b1, 8'd0,  8'd1}
    };

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic edges(input int n);
        for (int k = 0; k < n; k++) @(posedge clk);
        #1;
    endtask

    initial begin : watchdog
        #400000;
        n_fail++; n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(8'h90, d); check("R1 enable", int'(d), 0);
        rd(8'h94, d); check("R1 mode", int'(d), 0);
        rd(8'h98, d); check("R1 filter", int'(d), 0);
        rd(8'h9C, d); check("R1 period", int'(d), 255);
        check("R1 outputs", int'(irq_out), 0);

        // R2: write outside the window is ignored
        wr(8'h8C, 32'hFFFF_FFFF);
        wr(8'hA0, 32'hFFFF_FFFF);
        rd(8'h90, d); check("R2 enable untouched", int'(d), 0);
        rd(8'h9C, d); check("R2 period untouched", int'(d), 255);
        rd(8'hA0, d); check("R2 unmapped reads 0", int'(d), 0);
        wr(8'h94, 32'hFFFF_FFFF);
        rd(8'h94, d); check("R2 mode width", int'(d), 32'h00FF_FFFF);
        wr(8'h94, 32'h0);

        // R3: unfiltered latency, line 0
        wr(8'h90, 32'h1);
        @(negedge clk); irq_in[0] = 1'b1;
        edges(2); check("R3 before edge 3", int'(irq_out[0]), 0);
        edges(1); check("R3 at edge 3", int'(irq_out[0]), 1);
        @(negedge clk); irq_in[0] = 1'b0;
        edges(3); check("R3 falls at edge 3", int'(irq_out[0]), 0);

        // R4: filtered acceptance at edge 2+P with P=4
        wr(8'h98, 32'h1);
        wr(8'h9C, 32'd4);
        repeat (4) @(negedge clk);
        irq_in[0] = 1'b1;
        edges(5); check("R4 before edge 6", int'(irq_out[0]), 0);
        edges(1); check("R4 at edge 6", int'(irq_out[0]), 1);
        @(negedge clk); irq_in[0] = 1'b0;
        repeat (10) @(negedge clk);

        // R5: glitch restarts count: 3 high, 1 low, 3 high with P=4
        begin
            int seen = 0;
            for (int c = 0; c < 24; c++) begin
                @(negedge clk);
                irq_in[0] = (c < 3) || (c >= 4 && c < 7);
                @(posedge clk); #1;
                if (irq_out[0]) seen++;
            end
            check("R5 glitch never accepted", seen, 0);
        end

        // R9: shared period P=3 on lines 5 and 20
        wr(8'h90, 32'h0010_0020);
        wr(8'h98, 32'h0010_0020);
        wr(8'h9C, 32'd3);
        for (int w = 2; w <= 3; w++) begin
            int s5 = 0, s20 = 0;
            for (int c = 0; c < 20; c++) begin
                @(negedge clk);
                irq_in[5] = (c < w); irq_in[20] = (c < w);
                @(posedge clk); #1;
                if (irq_out[5]) s5++;
                if (irq_out[20]) s20++;
            end
            check("R9 line 5", s5 > 0, w >= 3);
            check("R9 line 20", s20 > 0, w >= 3);
        end

        // Table of scenarios on line L
        for (int v = 0; v < 9; v++) begin
            logic m, f, e;
            int p, w, pe, ok, hi, lo;
            {m, f, e} = VEC[v][18:16];
            p = int'(VEC[v][15:8]);
            w = int'(VEC[v][7:0]);
            wr(8'h9C, {24'h0, VEC[v][15:8]});
            wr(8'h98, f ? (32'h1 << L) : 32'h0);
            wr(8'h94, m ? (32'h1 << L) : 32'h0);
            wr(8'h90, e ? (32'h1 << L) : 32'h0);
            repeat (10) @(negedge clk);
            pe = (p == 0) ? 1 : p;
            ok = (!f || (w >= pe)) ? 1 : 0;
            hi = 0; lo = 0;
            for (int c = 0; c < 40; c++) begin
                @(negedge clk);
                irq_in[L] = (c < w);
                @(posedge clk); #1;
                if (irq_out[L]) hi++; else lo++;
            end
            if (!m) begin
                // R3 R4 R6: pass-through seen high only if enabled and accepted
                check($sformatf("R4 R6 vec %0d level", v), hi > 0, (e && ok) ? 1 : 0);
            end else if (e && f) begin
                // R7: two one-cycle lows per accepted pulse
                check($sformatf("R7 vec %0d lows", v), lo, ok ? 2 : 0);
            end else if (!f) begin
                check($sformatf("R8 vec %0d lows", v), lo, 0);
            end else begin
                check($sformatf("R6 vec %0d lows", v), lo, 0);
            end
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule